// File: doc/BRIEF.md
# USB Receive Endpoint Packet-Ready Control

This block holds the upper control and status byte of one USB receive endpoint. It also tracks the packet-ready flag for the packet that sits in the receive FIFO. A CPU bus writes and reads the byte. A FIFO unload interface reports every read from the receive FIFO: a CPU read removes one byte and a DMA read removes four. The reception logic reports each incoming packet with its byte count, a short-packet flag, an isochronous flag, a PID error flag and an incomplete-packet flag. The maximum packet size comes in as a configuration input.

A three-state machine follows the packet held in the FIFO. ST_EMPTY means no packet is held. ST_FULL means a maximum-size packet is held. ST_SHORT means a shorter packet is held. The transitions are:

- T_ARRIVE_FULL (ST_EMPTY to ST_FULL): a full-size packet arrives.
- T_ARRIVE_SHORT (ST_EMPTY to ST_SHORT): a short packet arrives.
- T_AUTO_DRAIN (ST_FULL to ST_EMPTY): auto-clear is set and the unloaded byte count reaches the maximum.
- T_SW_RELEASE (ST_FULL or ST_SHORT to ST_EMPTY): software clears packet-ready.

Packet-ready is high in every state except ST_EMPTY. When packet-ready falls and auto-request is set, the request-packet flag is raised again, so the next IN request goes out without software.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset, every bit of the control byte is 0, and packet-ready, request-packet and DMA request are 0. The byte reads as bit 7 auto-clear, bit 6 auto-request, bit 5 DMA enable, bit 4 PID error, bit 3 DMA mode, bit 2 toggle write enable, bit 1 data toggle, bit 0 incomplete.
- R2: In ST_FULL with auto-clear at 1, packet-ready falls at the clock edge where the unloaded byte count reaches the maximum packet size. It stays set while fewer bytes have been unloaded.
- R3: A short packet never clears packet-ready by itself, however many bytes are unloaded. Only a software release clears it. A packet counts as full only when the short flag is 0 and the byte count equals the maximum packet size.
- R4: Each CPU unload strobe adds 1 to the unload count and each DMA unload strobe adds 4.
- R5: When auto-request is 1 at the edge where packet-ready falls, request-packet is set at that same edge. When auto-request is 0, request-packet is left unchanged.
- R6: When a short packet is accepted, auto-request is cleared in the same cycle. This hardware clear takes priority over a bus write.
- R7: A bus write changes the data toggle to write-data bit 1 only when the stored toggle write enable is already 1. Otherwise the toggle keeps its value.
- R8: The toggle write enable is cleared on the cycle after a write that updated the toggle. The toggle flips on each accepted non-isochronous packet, and bit 1 always reads the live toggle.
- R9: An accepted packet with the incomplete flag sets bit 0. An accepted isochronous packet with a PID error sets bit 4. Software clears either bit by writing 0, and a hardware set wins over a bus write in the same cycle.
- R10: The DMA request is 0 whenever DMA enable is 0. In mode 0 (bit 3 = 0) it equals packet-ready.
- R11: In mode 1 (bit 3 = 1), the DMA request is 1 only in ST_FULL.
- R12: The unload count returns to 0 whenever packet-ready is cleared. A packet that was partly unloaded and then released by software does not shorten the count for the next packet.
- R13: A packet is accepted only in ST_EMPTY. An arrival while packet-ready is set changes nothing. An accepted packet clears request-packet, and a software request strobe sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the control byte |
| bus_wdata | input | 8 | Write data for the control byte |
| bus_rdata | output | 8 | Live value of the control byte |
| sw_ready_clr | input | 1 | Software release of packet-ready |
| sw_req_set | input | 1 | Software request-packet strobe |
| unload_cpu | input | 1 | One byte was read from the FIFO by the CPU |
| unload_dma | input | 1 | Four bytes were read from the FIFO by DMA |
| pkt_valid | input | 1 | A received packet is reported this cycle |
| pkt_bytes | input | CW | Byte count of the reported packet |
| pkt_short | input | 1 | The reported packet ended short |
| pkt_iso | input | 1 | The reported packet is isochronous |
| pkt_pid_err | input | 1 | A PID error was seen in the packet |
| pkt_incomp | input | 1 | A high-bandwidth packet is missing data |
| max_pkt | input | CW | Configured maximum packet size in bytes |
| pkt_ready | output | 1 | A packet is held in the FIFO |
| req_pkt | output | 1 | Request-packet flag |
| dma_req | output | 1 | DMA request |
| data_toggle | output | 1 | Current data toggle |

## Verification
A wrong state in the machine shows at the ports at the next clock edge. Packet-ready would fall early or late against the unload strobes, the DMA request in mode 1 would follow short packets, or request-packet would rise without the fall of packet-ready. A wrong unload count shows only at the end of a packet, as an auto-clear that is one strobe early or late. For this reason the bench walks packets right up to the byte-count boundary. A lost toggle write enable or a wrong toggle shows in the read byte within one cycle of the write or of the arrival.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FULL  = 2'd1,
        ST_SHORT = 2'd2
    } rdy_state_t;

    // Field order sets the bit position of each field in the bus byte.
    typedef struct packed {
        logic aclr;
        logic areq;
        logic dma_en;
        logic pid_err;
        logic dma_mode;
        logic twen;
        logic tog;
        logic incomp;
    } ctl_byte_t;

    localparam int DMA_UNIT = 4;

endpackage

// File: rtl/rx_unload_cnt.sv
module rx_unload_cnt
    import usb_rx_ep_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cpu_rd,
    input  logic          dma_rd,
    input  logic [CW-1:0] max_pkt,
    output logic          reach
);
    localparam int SW = CW + 1;

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sum;
    logic [CW-1:0] cnt_d;
    logic          any_rd;

    always_comb begin
        any_rd = cpu_rd | dma_rd;
        sum    = {1'b0, cnt_q}
               + (cpu_rd ? SW'(1) : SW'(0))
               + (dma_rd ? SW'(DMA_UNIT) : SW'(0));
        cnt_d  = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        reach  = any_rd && (sum >= {1'b0, max_pkt});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rx_pkt_fsm.sv
module rx_pkt_fsm
    import usb_rx_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_valid,
    input  logic full_pkt,
    input  logic sw_clr,
    input  logic sw_req,
    input  logic aclr_en,
    input  logic areq_en,
    input  logic reach,
    output logic ready,
    output logic held_full,
    output logic accept,
    output logic drop,
    output logic req
);
    rdy_state_t state_q;
    rdy_state_t state_d;
    logic       req_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (pkt_valid) begin
                    state_d = full_pkt ? ST_FULL : ST_SHORT;   // T_ARRIVE_FULL / T_ARRIVE_SHORT
                end
            end
            ST_FULL: begin
                if (sw_clr || (aclr_en && reach)) begin
                    state_d = ST_EMPTY;                        // T_SW_RELEASE / T_AUTO_DRAIN
                end
            end
            ST_SHORT: begin
                if (sw_clr) begin
                    state_d = ST_EMPTY;                        // T_SW_RELEASE
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        ready     = 1'b0;
        held_full = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_EMPTY: accept = pkt_valid;
            ST_FULL: begin
                ready     = 1'b1;
                held_full = 1'b1;
            end
            ST_SHORT: ready = 1'b1;
            default: ready = 1'b0;
        endcase
        drop = ready && (state_d == ST_EMPTY);
        req  = req_q;
    end

    // Request-packet flag: a set wins over the clear from an accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if ((drop && areq_en) || sw_req) begin
            req_q <= 1'b1;
        end else if (accept) begin
            req_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_ctl_byte.sv
module rx_ctl_byte
    import usb_rx_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       accept,
    input  logic       full_pkt,
    input  logic       iso,
    input  logic       pid_err,
    input  logic       incomp,
    output ctl_byte_t  ctl
);
    ctl_byte_t ctl_q;
    ctl_byte_t ctl_d;
    ctl_byte_t wr_v;
    logic      tog_wr_q;

    assign wr_v = ctl_byte_t'(bus_wdata);

    always_comb begin
        ctl_d = ctl_q;
        // Software write
        if (bus_wr) begin
            ctl_d.aclr     = wr_v.aclr;
            ctl_d.areq     = wr_v.areq;
            ctl_d.dma_en   = wr_v.dma_en;
            ctl_d.pid_err  = wr_v.pid_err;
            ctl_d.dma_mode = wr_v.dma_mode;
            ctl_d.twen     = wr_v.twen;
            ctl_d.incomp   = wr_v.incomp;
            if (ctl_q.twen) begin
                ctl_d.tog = wr_v.tog;
            end
        end
        // Hardware updates override software
        if (tog_wr_q) begin
            ctl_d.twen = 1'b0;
        end
        if (accept) begin
            if (!full_pkt) begin
                ctl_d.areq = 1'b0;
            end
            if (iso && pid_err) begin
                ctl_d.pid_err = 1'b1;
            end
            if (incomp) begin
                ctl_d.incomp = 1'b1;
            end
            if (!iso) begin
                ctl_d.tog = ~ctl_q.tog;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            tog_wr_q <= 1'b0;
        end else begin
            ctl_q    <= ctl_d;
            tog_wr_q <= bus_wr && ctl_q.twen;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
    import usb_rx_ep_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          sw_ready_clr,
    input  logic          sw_req_set,
    input  logic          unload_cpu,
    input  logic          unload_dma,
    input  logic          pkt_valid,
    input  logic [CW-1:0] pkt_bytes,
    input  logic          pkt_short,
    input  logic          pkt_iso,
    input  logic          pkt_pid_err,
    input  logic          pkt_incomp,
    input  logic [CW-1:0] max_pkt,
    output logic          pkt_ready,
    output logic          req_pkt,
    output logic          dma_req,
    output logic          data_toggle
);
    ctl_byte_t ctl;
    logic      full_pkt;
    logic      reach;
    logic      ready;
    logic      held_full;
    logic      accept;
    logic      drop;
    logic      req;

    assign full_pkt = !pkt_short && (pkt_bytes == max_pkt);

    rx_unload_cnt #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (drop || !ready),
        .cpu_rd  (unload_cpu),
        .dma_rd  (unload_dma),
        .max_pkt (max_pkt),
        .reach   (reach)
    );

    rx_pkt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .full_pkt  (full_pkt),
        .sw_clr    (sw_ready_clr),
        .sw_req    (sw_req_set),
        .aclr_en   (ctl.aclr),
        .areq_en   (ctl.areq),
        .reach     (reach),
        .ready     (ready),
        .held_full (held_full),
        .accept    (accept),
        .drop      (drop),
        .req       (req)
    );

    rx_ctl_byte u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .accept    (accept),
        .full_pkt  (full_pkt),
        .iso       (pkt_iso),
        .pid_err   (pkt_pid_err),
        .incomp    (pkt_incomp),
        .ctl       (ctl)
    );

    always_comb begin
        bus_rdata   = ctl;
        pkt_ready   = ready;
        req_pkt     = req;
        data_toggle = ctl.tog;
        dma_req     = ctl.dma_en && ready && (!ctl.dma_mode || held_full);
    end

endmodule

// File: rtl/rx_ep_checker.sv
module rx_ep_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       sw_ready_clr,
    input logic       pkt_valid,
    input logic       pkt_short,
    input logic       pkt_incomp,
    input logic       pkt_ready,
    input logic       req_pkt,
    input logic       dma_req,
    input logic       data_toggle
);
    // R2: a fall of packet-ready without a software release needs auto-clear
    a_r2_hw_clear_needs_aclr: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pkt_ready) && !$past(sw_ready_clr)) |-> $past(bus_rdata[7]));

    // R5: auto-request re-arms the request on the fall of packet-ready
    a_r5_autoreq_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pkt_ready) && $past(bus_rdata[6])) |-> req_pkt);

    // R6: an accepted short packet clears auto-request
    a_r6_short_drops_areq: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && pkt_short) |=> !bus_rdata[6]);

    // R7: with write enable low and no arrival the toggle holds
    a_r7_toggle_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rdata[2] && !(pkt_valid && !pkt_ready)) |=> $stable(data_toggle));

    // R8: write enable is gone two cycles after a write made with it set
    a_r8_twen_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rdata[2]) |=> ##1 !bus_rdata[2]);

    // R9: incomplete arrival sets bit 0
    a_r9_incomp_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && pkt_incomp) |=> bus_rdata[0]);

    // R10: no DMA request while disabled
    a_r10_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[5] |-> !dma_req);

    // R11: a DMA request needs a held packet
    a_r11_dma_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> pkt_ready);

    // R1: the live toggle output matches bit 1 of the read byte
    a_r1_toggle_readback: assert property (@(posedge clk) disable iff (!rst_n)
        data_toggle == bus_rdata[1]);

endmodule

bind usb_rx_ep_ctrl rx_ep_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .sw_ready_clr (sw_ready_clr),
    .pkt_valid    (pkt_valid),
    .pkt_short    (pkt_short),
    .pkt_incomp   (pkt_incomp),
    .pkt_ready    (pkt_ready),
    .req_pkt      (req_pkt),
    .dma_req      (dma_req),
    .data_toggle  (data_toggle)
);

// File: tb/usb_rx_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_rx_ep_ctrl_test;
    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          sw_ready_clr = 1'b0;
    logic          sw_req_set = 1'b0;
    logic          unload_cpu = 1'b0;
    logic          unload_dma = 1'b0;
    logic          pkt_valid = 1'b0;
    logic [CW-1:0] pkt_bytes = '0;
    logic          pkt_short = 1'b0;
    logic          pkt_iso = 1'b0;
    logic          pkt_pid_err = 1'b0;
    logic          pkt_incomp = 1'b0;
    logic [CW-1:0] max_pkt = CW'(8);
    logic          pkt_ready;
    logic          req_pkt;
    logic          dma_req;
    logic          data_toggle;

    always #2.5 clk = ~clk;

    usb_rx_ep_ctrl #(.CW(CW)) uut (.*);

    typedef struct {
        string      req;
        logic [11:0] exp;
    } item_t;

    item_t queue_q[$];
    int    n_run = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done = 1'b0;

    // Observed vector: ready, request, dma, toggle, then the read byte.
    function automatic logic [11:0] ev(input logic r, input logic q, input logic d,
                                       input logic [7:0] rd);
        return {r, q, d, rd[1], rd};
    endfunction

    task automatic expect_v(input string req, input logic [11:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        queue_q.push_back(it);
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (queue_q.size() > 0) begin
                item_t it;
                logic [11:0] act;
                it = queue_q.pop_front();
                act = {pkt_ready, req_pkt, dma_req, data_toggle, bus_rdata};
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    // Driver tasks: called at a falling edge, return at the next one.
    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pkt(input int bytes, input logic sh, input logic iso,
                       input logic pe, input logic inc);
        pkt_valid = 1'b1; pkt_bytes = CW'(bytes); pkt_short = sh;
        pkt_iso = iso; pkt_pid_err = pe; pkt_incomp = inc;
        @(negedge clk);
        pkt_valid = 1'b0; pkt_short = 1'b0; pkt_iso = 1'b0;
        pkt_pid_err = 1'b0; pkt_incomp = 1'b0;
    endtask

    task automatic rd_cpu(input int n);
        for (int i = 0; i < n; i++) begin
            unload_cpu = 1'b1;
            @(negedge clk);
            unload_cpu = 1'b0;
        end
    endtask

    task automatic rd_dma(input int n);
        for (int i = 0; i < n; i++) begin
            unload_dma = 1'b1;
            @(negedge clk);
            unload_dma = 1'b0;
        end
    endtask

    task automatic sw_clr();
        sw_ready_clr = 1'b1;
        @(negedge clk);
        sw_ready_clr = 1'b0;
    endtask

    task automatic sw_req();
        sw_req_set = 1'b1;
        @(negedge clk);
        sw_req_set = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_v("R1 reset state", ev(0, 0, 0, 8'h00));

        wr(8'hC0);
        expect_v("R1 byte layout auto-clear/auto-request", ev(0, 0, 0, 8'hC0));
        sw_req();
        expect_v("R13 software request sets flag", ev(0, 1, 0, 8'hC0));
        pkt(8, 0, 0, 0, 0);
        expect_v("R13 accepted packet clears request, R8 toggle flips", ev(1, 0, 0, 8'hC2));
        rd_cpu(7);
        expect_v("R2 one byte short of maximum keeps ready", ev(1, 0, 0, 8'hC2));
        rd_cpu(1);
        expect_v("R2 auto-clear at maximum, R5 auto-request", ev(0, 1, 0, 8'hC2));

        pkt(8, 0, 0, 0, 0);
        expect_v("R8 toggle flips back", ev(1, 0, 0, 8'hC0));
        rd_dma(1);
        expect_v("R4 one DMA read is four bytes", ev(1, 0, 0, 8'hC0));
        rd_dma(1);
        expect_v("R4 two DMA reads reach eight", ev(0, 1, 0, 8'hC0));

        pkt(3, 1, 0, 0, 0);
        expect_v("R6 short packet clears auto-request", ev(1, 0, 0, 8'h82));
        rd_cpu(10);
        expect_v("R3 short packet not auto-cleared", ev(1, 0, 0, 8'h82));
        sw_clr();
        expect_v("R3 software release, R5 no request without auto-request", ev(0, 0, 0, 8'h82));

        wr(8'h20);
        expect_v("R10 enable with no packet", ev(0, 0, 0, 8'h22));
        pkt(8, 0, 0, 0, 0);
        expect_v("R10 mode 0 follows ready", ev(1, 0, 1, 8'h20));
        wr(8'h00);
        expect_v("R10 disabled drops request", ev(1, 0, 0, 8'h00));
        wr(8'h28);
        expect_v("R11 mode 1 with full packet", ev(1, 0, 1, 8'h28));
        sw_clr();
        expect_v("R10 request follows ready low", ev(0, 0, 0, 8'h28));
        pkt(8, 1, 0, 0, 0);
        expect_v("R11 mode 1 silent on short packet", ev(1, 0, 0, 8'h2A));
        wr(8'h20);
        expect_v("R10 mode 0 on short packet", ev(1, 0, 1, 8'h22));
        sw_clr();
        expect_v("R10 released", ev(0, 0, 0, 8'h22));

        wr(8'h00);
        expect_v("R7 toggle write ignored while locked", ev(0, 0, 0, 8'h02));
        wr(8'h04);
        expect_v("R7 enable set, toggle kept", ev(0, 0, 0, 8'h06));
        wr(8'h04);
        expect_v("R7 toggle written while enabled", ev(0, 0, 0, 8'h04));
        @(negedge clk);
        expect_v("R8 write enable self-clears", ev(0, 0, 0, 8'h00));

        pkt(8, 0, 1, 1, 1);
        expect_v("R9 PID error and incomplete set, iso keeps toggle", ev(1, 0, 0, 8'h11));
        wr(8'h00);
        expect_v("R9 software clears status", ev(1, 0, 0, 8'h00));
        sw_clr();
        expect_v("R9 released", ev(0, 0, 0, 8'h00));
        bus_wr = 1'b1; bus_wdata = 8'h00;
        pkt(8, 0, 1, 1, 1);
        bus_wr = 1'b0;
        expect_v("R9 hardware set wins over write", ev(1, 0, 0, 8'h11));
        sw_clr();
        wr(8'h80);
        expect_v("R12 auto-clear only", ev(0, 0, 0, 8'h80));

        pkt(8, 0, 0, 0, 0);
        rd_cpu(5);
        sw_clr();
        expect_v("R12 partial unload released", ev(0, 0, 0, 8'h82));
        pkt(8, 0, 0, 0, 0);
        expect_v("R12 new full packet", ev(1, 0, 0, 8'h80));
        pkt(8, 0, 0, 0, 0);
        expect_v("R13 arrival while held ignored", ev(1, 0, 0, 8'h80));
        rd_cpu(7);
        expect_v("R12 count restarted from zero", ev(1, 0, 0, 8'h80));
        rd_cpu(1);
        expect_v("R12 auto-clear after full count", ev(0, 0, 0, 8'h80));

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule